// File: doc/BRIEF.md
# Packet Buffer Host Data Port

This block lets a host processor move data into and out of an on-chip packet buffer through two registers: a pointer register and a data register. The pointer register holds an 11-bit byte address, split into a 3-bit high field and an 8-bit low field, a direction bit, and a read-only flag. The flag shows that posted writes are still on their way to the buffer. The data register is backed by two small one-way FIFOs. A write FIFO posts host writes into the buffer RAM. A read prefetch FIFO fetches dwords ahead of the pointer, so host reads complete without waiting for the RAM.

Host cycles are framed by the active-low `rd_n` and `wr_n` strobes, which carry no bus clock. Each strobe is synchronised into the block clock, and the access takes effect once, when the strobe is released. The size of a normal access is set by the byte enables and `a1`, and sizes may change from one cycle to the next. A second chip select, `dcs_n`, gives direct access to the data register. It always moves a full dword and ignores `a1` and the byte enables. After each access the pointer advances by the number of bytes moved. The buffer is always addressed in whole dwords, so the two low pointer bits never choose a RAM word.

Back-pressure is carried by plain status pins. `wr_ready` is low while the write FIFO is full, and a data write that arrives then is dropped and reported on `wr_drop`. `rd_valid` is high while a prefetched dword waits at the head of the read FIFO.

Top module: `pbuf_host_port`

## Requirements
- R1: After reset the pointer is 0, the direction is write, `wr_ready` is 1, and `rd_valid`, `wf_pending` and `wr_drop` are 0.
- R2: `wf_pending`, also shown as pointer bit 14, is 1 while the write FIFO holds entries not yet written to the buffer, and it returns to 0 once they are drained.
- R3: A write with `cs_n`=0, `dcs_n`=1 and `reg_sel`=1 loads the pointer: bits [10:8] are the high field, bits [7:0] the low field, and bit 15 is the direction (1 = read). A read of the same register returns the address in [10:0], the pending flag in bit 14 and the direction in bit 15. The buffer dword used is pointer[10:2].
- R4: While `dcs_n`=0, every data access moves all four lanes and advances the pointer by 4, whatever `a1`, `be_n` and `reg_sel` are.
- R5: A normal data access uses lanes ~`be_n` when `a1`=0. When `a1`=1 it uses `~be_n[1:0]` placed on lanes 3:2, with write data taken from `wdata[15:0]` and read data returned on `rdata[15:0]`. The pointer advances by the number of lanes used, and an access with no lanes does nothing.
- R6: A pointer write flushes the read prefetch FIFO. When bit 15 is 1, prefetch restarts from the new pointer dword once the write FIFO is empty.
- R7: A data write while the direction is read has no effect on the pointer or the buffer. A data read while the direction is write returns 0 and leaves the pointer unchanged.
- R8: The write FIFO holds 12 bytes (3 dword entries). While it is full `wr_ready` is 0, and a further data write is dropped: the buffer and the pointer are unchanged and `wr_drop` pulses for one cycle.
- R9: Successive data reads return the buffer contents at consecutive pointer positions, with the prefetch FIFO refilling from the following dwords.
- R10: Each strobe pulse, however long, performs exactly one access, taken when the strobe is released.
- R11: `rd_valid` becomes 1 within a few cycles of a read-direction pointer write when no writes are pending, and it is 0 after a write-direction pointer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Normal register chip select, active low |
| dcs_n | input | 1 | Direct data-register chip select, active low, forces 32-bit access |
| reg_sel | input | 1 | Normal mode register choice: 1 = pointer, 0 = data |
| a1 | input | 1 | Halfword select for normal accesses |
| be_n | input | 4 | Byte-lane enables, active low |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Host read data |
| wr_ready | output | 1 | Write FIFO can accept a data write |
| rd_valid | output | 1 | Prefetched read data is available |
| wr_drop | output | 1 | One-cycle pulse when a data write is dropped |
| wf_pending | output | 1 | Write FIFO still holds undrained data |

## Verification
The bench builds the block with `WR_CYCLES` = 64, so every buffer write keeps the RAM busy for 64 cycles. At this value, posted host writes pile up faster than they drain. The write FIFO therefore fills, and the dropped-write path and the pending flag become observable. The other parameters keep their defaults (a 2 KB buffer and 12-byte FIFOs), so pointer wrap and both address fields stay within reach of random accesses.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

  typedef struct packed {
    logic       is_ptr;
    logic       is_dat;
    logic       direct;
    logic [3:0] lanes;
  } pbuf_acc_t;

  function automatic logic [2:0] lane_bytes(input logic [3:0] l);
    return 3'(l[0]) + 3'(l[1]) + 3'(l[2]) + 3'(l[3]);
  endfunction

endpackage

// File: rtl/pbuf_strobe_sync.sv
module pbuf_strobe_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strobe_n,
  output logic [N-1:0] release_p
);

  for (genvar g = 0; g < N; g++) begin : g_strobe
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
        s3 <= 1'b1;
      end else begin
        s1 <= strobe_n[g];
        s2 <= s1;
        s3 <= s2;
      end
    end

    assign release_p[g] = s2 & ~s3;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      release_p[g] |=> !release_p[g]); // R10
  end

endmodule

// File: rtl/pbuf_fifo.sv
module pbuf_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 3,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] rp, wp;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full  = (32'(count) == DEPTH);
  assign empty = (count == '0);
  assign dout  = slots[rp];

  always_ff @(posedge clk) begin
    if (push && !flush) slots[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
    end else if (flush) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full && !pop && !flush)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty && !flush)); // R9

endmodule

// File: rtl/pbuf_ram.sv
module pbuf_ram #(
  parameter int AW        = 9,
  parameter int WR_CYCLES = 1,
  localparam int WORDS    = 1 << AW,
  localparam int BW       = $clog2(WR_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [3:0]    wmask,
  input  logic [31:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] addr,
  output logic [31:0]   rdata,
  output logic          ready
);

  logic [31:0]   mem [WORDS];
  logic [BW-1:0] busy;

  assign ready = (busy == '0);

  always_ff @(posedge clk) begin
    if (we && ready) begin
      for (int b = 0; b < 4; b++) begin
        if (wmask[b]) mem[addr][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
    if (re && ready) rdata <= mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              busy <= '0;
    else if (we && ready)    busy <= BW'(WR_CYCLES - 1);
    else if (busy != '0)     busy <= busy - 1'b1;
  end

  AST_ONE_PORT_USE: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re)); // R6

endmodule

// File: rtl/pbuf_host_port.sv
module pbuf_host_port #(
  parameter int PTR_HI_W   = 3,
  parameter int PTR_LO_W   = 8,
  parameter int FIFO_BYTES = 12,
  parameter int WR_CYCLES  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        dcs_n,
  input  logic        reg_sel,
  input  logic        a1,
  input  logic [3:0]  be_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        wr_ready,
  output logic        rd_valid,
  output logic        wr_drop,
  output logic        wf_pending
);
  import pbuf_pkg::*;

  localparam int AW    = PTR_HI_W + PTR_LO_W;
  localparam int DAW   = AW - 2;
  localparam int DEPTH = FIFO_BYTES / 4;
  localparam int WF_W  = DAW + 4 + 32;
  localparam int CW    = $clog2(DEPTH + 1);

  // strobe release detection
  logic [1:0] rel;
  logic       rd_done, wr_done;

  pbuf_strobe_sync #(.N(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n({wr_n, rd_n}), .release_p(rel)
  );
  assign rd_done = rel[0];
  assign wr_done = rel[1];

  // access decode
  pbuf_acc_t   acc;
  logic [31:0] lane_wdata;
  logic [2:0]  nbytes;

  always_comb begin
    acc.direct = !dcs_n;
    acc.is_ptr = !cs_n && dcs_n && reg_sel;
    acc.is_dat = !dcs_n || (!cs_n && !reg_sel);
    if (!dcs_n)  acc.lanes = 4'hF;
    else if (a1) acc.lanes = {~be_n[1:0], 2'b00};
    else         acc.lanes = ~be_n;
    lane_wdata = (dcs_n && a1) ? {wdata[15:0], 16'h0000} : wdata;
  end
  assign nbytes = lane_bytes(acc.lanes);

  // pointer state
  logic [AW-1:0] ptr, ptr_next;
  logic          dir;

  // fifo wiring
  logic [WF_W-1:0] wf_din, wf_dout;
  logic            wf_full, wf_empty, wf_pop;
  logic [CW-1:0]   wf_count;
  logic [31:0]     rf_dout;
  logic            rf_full, rf_empty, rf_pop, rf_push;
  logic [CW-1:0]   rf_count;

  // ram wiring
  logic            ram_we, ram_re, ram_ready;
  logic [DAW-1:0]  ram_addr;
  logic [31:0]     ram_rdata;

  // prefetch state
  logic [DAW-1:0]  pf_addr;
  logic            pf_inflight, pf_issue, pf_room;

  logic ev_ptr_wr, ev_dat_wr, ev_dat_rd, wr_acc, wr_lost, rd_acc;

  assign ev_ptr_wr = wr_done && acc.is_ptr;
  assign ev_dat_wr = wr_done && acc.is_dat;
  assign ev_dat_rd = rd_done && acc.is_dat;
  assign wr_acc    = ev_dat_wr && !dir && (nbytes != 3'd0) && !wf_full;
  assign wr_lost   = ev_dat_wr && !dir && (nbytes != 3'd0) && wf_full;
  assign rd_acc    = ev_dat_rd && dir && !rf_empty && (nbytes != 3'd0);
  assign ptr_next  = ptr + AW'(nbytes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      dir     <= 1'b0;
      wr_drop <= 1'b0;
    end else begin
      wr_drop <= wr_lost;
      if (ev_ptr_wr) begin
        ptr <= wdata[AW-1:0];
        dir <= wdata[15];
      end else if (wr_acc || rd_acc) begin
        ptr <= ptr_next;
      end
    end
  end

  // write path: posted entries drain into the RAM
  assign wf_din = {ptr[AW-1:2], acc.lanes, lane_wdata};
  assign ram_we = !wf_empty && ram_ready;
  assign wf_pop = ram_we;

  pbuf_fifo #(.W(WF_W), .DEPTH(DEPTH)) u_wfifo (
    .clk(clk), .rst_n(rst_n), .flush(1'b0),
    .push(wr_acc), .din(wf_din), .pop(wf_pop), .dout(wf_dout),
    .full(wf_full), .empty(wf_empty), .count(wf_count)
  );

  // read path: prefetch ahead of the pointer
  assign pf_room  = (32'(rf_count) + 32'(pf_inflight)) < DEPTH;
  assign pf_issue = dir && wf_empty && ram_ready && pf_room && !ev_ptr_wr;
  assign ram_re   = pf_issue;
  assign ram_addr = ram_we ? wf_dout[WF_W-1 -: DAW] : pf_addr;
  assign rf_push  = pf_inflight;
  assign rf_pop   = rd_acc && (ptr_next[AW-1:2] != ptr[AW-1:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_addr     <= '0;
      pf_inflight <= 1'b0;
    end else if (ev_ptr_wr) begin
      pf_addr     <= wdata[AW-1:2];
      pf_inflight <= 1'b0;
    end else begin
      pf_inflight <= pf_issue;
      if (pf_issue) pf_addr <= pf_addr + 1'b1;
    end
  end

  pbuf_fifo #(.W(32), .DEPTH(DEPTH)) u_rfifo (
    .clk(clk), .rst_n(rst_n), .flush(ev_ptr_wr),
    .push(rf_push), .din(ram_rdata), .pop(rf_pop), .dout(rf_dout),
    .full(rf_full), .empty(rf_empty), .count(rf_count)
  );

  pbuf_ram #(.AW(DAW), .WR_CYCLES(WR_CYCLES)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(ram_we), .wmask(wf_dout[35:32]), .wdata(wf_dout[31:0]),
    .re(ram_re), .addr(ram_addr), .rdata(ram_rdata), .ready(ram_ready)
  );

  // host read mux and status
  logic [15:0] ptr_word;
  always_comb begin
    ptr_word         = '0;
    ptr_word[AW-1:0] = ptr;
    ptr_word[14]     = !wf_empty;
    ptr_word[15]     = dir;
    rdata            = '0;
    if (acc.is_ptr) rdata = {16'h0000, ptr_word};
    else if (acc.is_dat && dir && !rf_empty)
      rdata = (dcs_n && a1) ? {16'h0000, rf_dout[31:16]} : rf_dout;
  end

  assign wr_ready   = !wf_full;
  assign rd_valid   = !rf_empty;
  assign wf_pending = !wf_empty;

  AST_DIRECT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dat_wr && !dcs_n && !dir && !wf_full) |=> ((ptr - $past(ptr)) == AW'(4))); // R4
  AST_PTR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ptr_wr |=> (rf_empty && !pf_inflight)); // R6
  AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dat_wr && !dir && wf_full && (nbytes != 3'd0)) |=> (wr_drop && $stable(ptr))); // R8
  AST_DIR_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dat_wr && dir) |=> $stable(ptr)); // R7
  AST_PENDING_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wf_pending) |-> $past(wr_acc)); // R2
  AST_PF_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(pf_inflight)); // R11

endmodule

// File: tb/pbuf_host_port_bench.sv
module pbuf_host_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, dcs_n = 1'b1, reg_sel = 1'b0, a1 = 1'b0;
  logic [3:0]  be_n = 4'hF;
  logic        rd_n = 1'b1, wr_n = 1'b1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wr_ready, rd_valid, wr_drop, wf_pending;

  int total = 0, bad = 0, drops = 0, cyc = 0;
  bit [31:0] mem_m [512];
  bit [10:0] eptr = '0;
  bit        edir = 1'b0;

  always #10 clk = ~clk;

  pbuf_host_port #(.WR_CYCLES(64)) u_pbuf_host_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dcs_n(dcs_n), .reg_sel(reg_sel),
    .a1(a1), .be_n(be_n), .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
    .rdata(rdata), .wr_ready(wr_ready), .rd_valid(rd_valid),
    .wr_drop(wr_drop), .wf_pending(wf_pending)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wr_drop) drops <= drops + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [3:0] lanes_of(input bit direct, input bit a, input bit [3:0] ben);
    if (direct) return 4'hF;
    if (a) return {~ben[1:0], 2'b00};
    return ~ben;
  endfunction

  function automatic int nb(input bit [3:0] l);
    return int'(l[0]) + int'(l[1]) + int'(l[2]) + int'(l[3]);
  endfunction

  // one host cycle; q is sampled while the strobe is low
  task automatic bus(input bit wr, input bit rsel, input bit direct, input bit a,
                     input bit [3:0] ben, input bit [31:0] d, input int low,
                     output logic [31:0] q);
    @(negedge clk);
    cs_n = direct; dcs_n = !direct; reg_sel = rsel; a1 = a; be_n = ben; wdata = d;
    @(negedge clk);
    if (wr) wr_n = 1'b0; else rd_n = 1'b0;
    repeat (low) @(negedge clk);
    q = rdata;
    wr_n = 1'b1; rd_n = 1'b1;
    repeat (5) @(negedge clk);
    cs_n = 1'b1; dcs_n = 1'b1;
  endtask

  task automatic set_ptr(input bit [10:0] p, input bit d);
    logic [31:0] q;
    bus(1, 1, 0, 0, 4'h0, {16'h0, d, 4'h0, p}, 4, q);
    eptr = p; edir = d;
  endtask

  function automatic bit [31:0] ptr_exp(input bit pend);
    return {16'h0, edir, pend, 3'b000, eptr};
  endfunction

  task automatic read_ptr(output logic [31:0] q);
    bus(0, 1, 0, 0, 4'hF, 0, 4, q);
  endtask

  // data write with model update (assumes accepted)
  task automatic dwrite(input bit direct, input bit a, input bit [3:0] ben, input bit [31:0] d);
    logic [31:0] q;
    bit [3:0] l;
    bit [31:0] ld;
    l = lanes_of(direct, a, ben);
    ld = (!direct && a) ? {d[15:0], 16'h0} : d;
    bus(1, 0, direct, a, ben, d, 4, q);
    for (int b = 0; b < 4; b++) if (l[b]) mem_m[eptr[10:2]][8*b +: 8] = ld[8*b +: 8];
    eptr = eptr + 11'(nb(l));
  endtask

  task automatic dread(input string tag, input bit direct, input bit a, input bit [3:0] ben);
    logic [31:0] q;
    bit [3:0] l;
    bit [31:0] w;
    l = lanes_of(direct, a, ben);
    w = mem_m[eptr[10:2]];
    bus(0, 0, direct, a, ben, 0, 4, q);
    chk(tag, q, (!direct && a) ? {16'h0, w[31:16]} : w);
    eptr = eptr + 11'(nb(l));
  endtask

  task automatic wait_sig(input string tag, input bit want_valid);
    int n = 0;
    while ((want_valid ? !rd_valid : (wf_pending || !wr_ready)) && n < 2000) begin
      @(negedge clk); n++;
    end
    if (n >= 2000) chk(tag, 32'd0, 32'd1);
  endtask

  initial begin : watchdog
    wait (cyc > 190000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] q;
    int d0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wr_ready", 32'(wr_ready), 1);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    chk("R1 wf_pending", 32'(wf_pending), 0);
    chk("R1 wr_drop", 32'(wr_drop), 0);
    read_ptr(q);
    chk("R1 pointer", q, 0);

    // R3 pointer fields
    set_ptr(11'h705, 0);
    read_ptr(q);
    chk("R3 pointer fields", q, ptr_exp(0));

    // fill buffer dwords 0..127 with direct writes (R4)
    set_ptr(11'h000, 0);
    for (int i = 0; i < 128; i++) begin
      wait_sig("R8 ready timeout", 0);
      dwrite(1, $urandom_range(0, 1), 4'($urandom), $urandom);
    end
    read_ptr(q);
    chk("R4 direct pointer step", q, ptr_exp(q[14]));
    wait_sig("R2 drain timeout", 0);

    // R2 pending flag while RAM busy
    set_ptr(11'h020, 0);
    dwrite(0, 0, 4'b1110, 32'h0000_00A5);
    dwrite(0, 1, 4'b1100, 32'h0000_BEEF);
    read_ptr(q);
    chk("R2 pending set", 32'(q[14]), 1);
    chk("R5 byte and halfword step", 32'(q[10:0]), 32'(eptr));
    wait_sig("R2 drain timeout", 0);
    chk("R2 pending clear", 32'(wf_pending), 0);

    // R8 overflow: idle RAM, then five quick writes
    repeat (80) @(negedge clk);
    set_ptr(11'h040, 0);
    d0 = drops;
    for (int i = 0; i < 4; i++) dwrite(1, 0, 4'h0, 32'h1111_0000 + 32'(i));
    chk("R8 full not ready", 32'(wr_ready), 0);
    bus(1, 0, 1, 0, 4'h0, 32'hDEAD_DEAD, 4, q);
    repeat (2) @(negedge clk);
    chk("R8 drop pulse", 32'(drops - d0), 1);
    read_ptr(q);
    chk("R8 pointer held", 32'(q[10:0]), 32'(eptr));
    wait_sig("R8 drain timeout", 0);

    // R6/R11/R9 read back
    set_ptr(11'h020, 1);
    wait_sig("R11 valid timeout", 1);
    chk("R11 rd_valid", 32'(rd_valid), 1);
    dread("R5 low half", 0, 0, 4'b1100);
    dread("R5 high half a1", 0, 1, 4'b1100);
    dread("R9 dword", 1, 0, 4'h0);
    // R7 writes ignored while reading
    bus(1, 0, 1, 0, 4'h0, 32'hFFFF_FFFF, 4, q);
    read_ptr(q);
    chk("R7 write ignored ptr", 32'(q[10:0]), 32'(eptr));
    wait_sig("R9 valid timeout", 1);
    dread("R7 data unchanged", 1, 0, 4'h0);
    // R10 long strobe is one access
    wait_sig("R10 valid timeout", 1);
    bus(0, 0, 1, 0, 4'h0, 0, 25, q);
    eptr = eptr + 11'd4;
    read_ptr(q);
    chk("R10 single step", 32'(q[10:0]), 32'(eptr));
    // R7 read while writing direction
    set_ptr(11'h050, 0);
    chk("R11 rd_valid cleared", 32'(rd_valid), 0);
    bus(0, 0, 1, 0, 4'h0, 0, 4, q);
    chk("R7 read gives zero", q, 0);
    read_ptr(q);
    chk("R7 read ptr held", 32'(q[10:0]), 32'(eptr));
    // R6 flush: restart elsewhere
    set_ptr(11'h010, 1);
    wait_sig("R6 valid timeout", 1);
    dread("R6 restart data", 1, 0, 4'h0);

    // random phase
    for (int it = 0; it < 30; it++) begin
      bit [10:0] base;
      int nw;
      base = 11'($urandom_range(0, 100) * 4);
      nw = $urandom_range(3, 6);
      set_ptr(base, 0);
      for (int k = 0; k < nw; k++) begin
        wait_sig("R8 ready timeout", 0);
        dwrite($urandom_range(0, 1), $urandom_range(0, 1), 4'($urandom), $urandom);
      end
      wait_sig("R2 drain timeout", 0);
      set_ptr(base, 1);
      for (int k = 0; k < 10; k++) begin
        bit [3:0] ben;
        ben = 4'($urandom_range(0, 14));
        wait_sig("R9 valid timeout", 1);
        dread("R9 random read", $urandom_range(0, 1), $urandom_range(0, 1), ben);
      end
      read_ptr(q);
      chk("R5 random pointer", 32'(q[10:0]), 32'(eptr));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule